// File: doc/BRIEF.md
# Dual-Channel Serial DAC Command Front End

This block is the digital control side of a two-channel 8-bit voltage DAC. A host writes 16-bit command words over a three-wire, clock-idle-low serial link (active-low select, clock, data). The block samples all serial pins on a fast system clock, gathers the word and acts on it when select returns high. Each channel has an input register, a DAC register that drives the converter code, and a shutdown flag.

The bits of the control byte each do one job and are not decoded as opcodes. Two address bits pick which input registers take the data byte. One bit turns on copying of both input registers into both DAC registers. A timing bit picks when that copy happens: at once when select rises, or later on a falling edge of a separate active-low load pin. A power bit sets or clears the shutdown flag of the addressed channels. Because of this double buffering, both channels can take new codes at the same moment.

Top module: `dac_cmd_front`

## Requirements
- R1: While reset is asserted, and after it is released until a command acts, both DAC outputs, both input registers, both shutdown flags and the deferred-load request are zero.
- R2: Data is taken on each rising serial clock edge while select is low, MSB first. In the 16-bit word, bits 15..13 are ignored, bit 12 is the power bit P, bit 11 the copy enable U, bit 10 the timing bit T, bit 9 selects channel B, bit 8 selects channel A, and bits 7..0 are the data byte.
- R3: A word sent as two 8-bit transfers with an idle pause between them, with select held low throughout, gives the same result as one unbroken transfer.
- R4: When select rises after exactly 16 bits, each addressed channel's input register takes the data byte. A channel that is not addressed keeps its input register.
- R5: With U=1 and T=0, both DAC outputs take their input register values, including data loaded by the same word, when select rises. With no channel addressed, only the copy takes place.
- R6: With U=1 and T=1, the copy waits for the first falling edge of the load pin seen while select is high. That edge updates both DAC outputs, and later edges do nothing.
- R7: P=1 sets and P=0 clears the shutdown flag of each addressed channel only. Output codes are kept while a channel is shut down, and a deferred copy still takes place during shutdown.
- R8: A word with P=0, U=0 and no channel addressed changes nothing, and leaves a pending deferred copy pending.
- R9: If select rises after any bit count other than 16, the word is discarded and no register or flag changes.
- R10: Any other completed word cancels a pending deferred copy. A falling edge on the load pin with nothing pending has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock, idle low, sampled on its rising edge |
| sdi | input | 1 | Serial data, MSB first |
| ld_n | input | 1 | Deferred-load strobe, acts on its falling edge |
| out_a | output | 8 | Channel A DAC register |
| out_b | output | 8 | Channel B DAC register |
| sd_a | output | 1 | Channel A shutdown flag |
| sd_b | output | 1 | Channel B shutdown flag |

## Verification
The stimulus drives load-only, copy-only, load-and-copy and deferred-copy words with different codes on each channel. These show whether the data reaches the right input register and whether both DAC registers copy together. Words with the ignored top bits set, and words split by a pause, confirm that only the bit positions matter. Short and long frames, the unassigned word sent over a pending request, and a cancelling word followed by a load pulse each leave a trace that a later copy brings out. Shutdown is set and cleared one channel at a time, so an error that touches both flags is caught.

// File: rtl/dac_cmd_front.sv
module dac_cmd_front #(
  parameter int DW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic          sdi,
  input  logic          ld_n,
  output logic [DW-1:0] out_a,
  output logic [DW-1:0] out_b,
  output logic          sd_a,
  output logic          sd_b
);
  localparam int WORD = DW + 8;
  localparam int SHW  = DW + 5;
  localparam int CW   = $clog2(WORD) + 1;

  logic [SYNC-1:0] cs_sr, ck_sr, dt_sr, ld_sr;
  logic            cs_q, ck_q, ld_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_sr <= '1;
      ck_sr <= '0;
      dt_sr <= '0;
      ld_sr <= '1;
      cs_q  <= 1'b1;
      ck_q  <= 1'b0;
      ld_q  <= 1'b1;
    end else begin
      cs_sr <= {cs_sr[SYNC-2:0], cs_n};
      ck_sr <= {ck_sr[SYNC-2:0], sclk};
      dt_sr <= {dt_sr[SYNC-2:0], sdi};
      ld_sr <= {ld_sr[SYNC-2:0], ld_n};
      cs_q  <= cs_sr[SYNC-1];
      ck_q  <= ck_sr[SYNC-1];
      ld_q  <= ld_sr[SYNC-1];
    end

  wire cs_s    = cs_sr[SYNC-1];
  wire ck_s    = ck_sr[SYNC-1];
  wire dt_s    = dt_sr[SYNC-1];
  wire ld_s    = ld_sr[SYNC-1];
  wire cs_fall = cs_q & ~cs_s;
  wire cs_rise = ~cs_q & cs_s;
  wire ck_rise = ~ck_q & ck_s & ~cs_s;
  wire ld_fall = ld_q & ~ld_s;

  logic [SHW-1:0] sh;
  logic [CW-1:0]  cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
    end else if (cs_fall) begin
      cnt <= '0;
    end else if (ck_rise) begin
      sh <= {sh[SHW-2:0], dt_s};
      if (cnt != '1) cnt <= cnt + 1'b1;
    end

  wire          p_bit = sh[DW+4];
  wire          u_bit = sh[DW+3];
  wire          t_bit = sh[DW+2];
  wire          sel_b = sh[DW+1];
  wire          sel_a = sh[DW];
  wire [DW-1:0] dat   = sh[DW-1:0];

  wire exec    = cs_rise && (cnt == CW'(WORD));
  wire idle_w  = !p_bit && !u_bit && !sel_a && !sel_b;
  wire act     = exec && !idle_w;

  logic [DW-1:0] in_a, in_b;
  logic          pend;

  wire [DW-1:0] nxt_a  = sel_a ? dat : in_a;
  wire [DW-1:0] nxt_b  = sel_b ? dat : in_b;
  wire          ld_fire = ld_fall && pend && cs_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_a  <= '0;
      in_b  <= '0;
      out_a <= '0;
      out_b <= '0;
      sd_a  <= 1'b0;
      sd_b  <= 1'b0;
      pend  <= 1'b0;
    end else if (act) begin
      in_a <= nxt_a;
      in_b <= nxt_b;
      if (sel_a) sd_a <= p_bit;
      if (sel_b) sd_b <= p_bit;
      if (u_bit && !t_bit) begin
        out_a <= nxt_a;
        out_b <= nxt_b;
      end
      pend <= u_bit && t_bit;
    end else if (ld_fire) begin
      out_a <= in_a;
      out_b <= in_b;
      pend  <= 1'b0;
    end
endmodule

// File: rtl/dac_cmd_front_chk.sv
module dac_cmd_front_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] out_a,
  input logic [DW-1:0] out_b,
  input logic [DW-1:0] in_a,
  input logic [DW-1:0] in_b,
  input logic          sd_a,
  input logic          sd_b,
  input logic          pend,
  input logic          exec,
  input logic          cs_rise,
  input logic          ld_fall,
  input logic          ld_fire
);
  // R1
  always @(negedge clk)
    if (!rst_n)
      reset_zero_chk: assert (out_a == '0 && out_b == '0 && !sd_a && !sd_b && !pend);

  // R5
  dac_change_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_a != $past(out_a) || out_b != $past(out_b)) |-> $past(exec || ld_fire));

  // R6
  deferred_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fire |=> (out_a == $past(in_a) && out_b == $past(in_b) && !pend));

  // R7
  sd_change_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_a != $past(sd_a) || sd_b != $past(sd_b)) |-> $past(exec));

  // R9
  bad_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !exec) |=> ($stable(out_a) && $stable(out_b) && $stable(sd_a) && $stable(sd_b)
                            && $stable(in_a) && $stable(in_b)));

  // R10
  stray_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_fall && !pend && !exec) |=> ($stable(out_a) && $stable(out_b)));
endmodule

bind dac_cmd_front dac_cmd_front_chk #(.DW(DW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .out_a   (out_a),
  .out_b   (out_b),
  .in_a    (in_a),
  .in_b    (in_b),
  .sd_a    (sd_a),
  .sd_b    (sd_b),
  .pend    (pend),
  .exec    (exec),
  .cs_rise (cs_rise),
  .ld_fall (ld_fall),
  .ld_fire (ld_fire)
);

// File: tb/test_dac_cmd_front.sv
module test_dac_cmd_front;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, ld_n = 1'b1;
  logic [7:0] out_a, out_b;
  logic sd_a, sd_b;

  always #4 clk = ~clk;

  dac_cmd_front i_dac_cmd_front (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .ld_n(ld_n),
    .out_a(out_a), .out_b(out_b), .sd_a(sd_a), .sd_b(sd_b)
  );

  typedef struct {
    logic [7:0] a;
    logic [7:0] b;
    logic       sa;
    logic       sb;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0] m_ina = 0, m_inb = 0, m_da = 0, m_db = 0;
  logic m_sa = 0, m_sb = 0, m_pend = 0;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_exp(input string tag);
    exp_t e;
    e.a = m_da; e.b = m_db; e.sa = m_sa; e.sb = m_sb; e.tag = tag;
    q.push_back(e);
    wait (q.size() == 0);
  endtask

  task automatic shift_bits(input logic [16:0] w, input int n, input bit pause);
    cs_n = 1'b0;
    wait_clk(4);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = w[i];
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
      if (pause && i == 8) wait_clk(40);
    end
    wait_clk(4);
    cs_n = 1'b1;
    wait_clk(6);
  endtask

  task automatic model_word(input logic [15:0] w);
    logic p, u, t, sb, sa;
    logic [7:0] d;
    {p, u, t, sb, sa} = w[12:8];
    d = w[7:0];
    if (!p && !u && !sa && !sb) return;
    if (sa) begin m_ina = d; m_sa = p; end
    if (sb) begin m_inb = d; m_sb = p; end
    if (u && !t) begin m_da = m_ina; m_db = m_inb; end
    m_pend = u && t;
  endtask

  task automatic frame(input logic [15:0] w, input bit pause, input string tag);
    shift_bits({1'b0, w}, 16, pause);
    model_word(w);
    push_exp(tag);
  endtask

  task automatic bad_frame(input logic [16:0] w, input int n, input string tag);
    shift_bits(w, n, 1'b0);
    push_exp(tag);
  endtask

  task automatic pulse_ld(input string tag);
    ld_n = 1'b0;
    wait_clk(6);
    ld_n = 1'b1;
    wait_clk(6);
    if (m_pend) begin m_da = m_ina; m_db = m_inb; m_pend = 0; end
    push_exp(tag);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      wait (q.size() > 0);
      wait_clk(12);
      e = q[0];
      checks++;
      if (out_a !== e.a || out_b !== e.b || sd_a !== e.sa || sd_b !== e.sb) begin
        fails++;
        $display("FAIL %s: got a=%h b=%h sa=%b sb=%b, expected a=%h b=%h sa=%b sb=%b",
                 e.tag, out_a, out_b, sd_a, sd_b, e.a, e.b, e.sa, e.sb);
      end
      void'(q.pop_front());
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    wait_clk(3);
    push_exp("R1 during reset");
    rst_n = 1'b1;
    wait_clk(3);
    push_exp("R1 after reset");

    frame(16'h013C, 0, "R4 load A only, outputs held");
    frame(16'h0800, 0, "R5 copy only shows A input");
    frame(16'hEAA5, 0, "R2 top bits ignored, load B and copy");
    frame(16'h0B81, 1, "R3 split transfer load both and copy");
    frame(16'h0D55, 0, "R6 deferred copy not yet applied");
    pulse_ld("R6 load edge applies copy");
    frame(16'h0222, 0, "R4 load B only");
    pulse_ld("R10 load edge with nothing pending ignored");
    frame(16'h1199, 0, "R7 shut down A only, codes kept");
    frame(16'h1D77, 0, "R7 deferred request while shut down");
    pulse_ld("R7 deferred copy during shutdown");
    pulse_ld("R6 second load edge ignored");
    frame(16'h0310, 0, "R7 wake both, codes kept");
    frame(16'h0C00, 0, "R8 setup pending copy");
    frame(16'h00FF, 0, "R8 unassigned word changes nothing");
    pulse_ld("R8 pending survived, no input loaded");
    bad_frame(17'h00BB7, 12, "R9 short frame discarded");
    bad_frame(17'h10BEE, 17, "R9 long frame discarded");
    frame(16'h0800, 0, "R9 inputs untouched by bad frames");
    frame(16'h0D44, 0, "R10 setup pending copy");
    frame(16'h0233, 0, "R10 new word cancels pending");
    pulse_ld("R10 cancelled copy not applied");
    frame(16'h0800, 0, "R10 copy shows both inputs");
    frame(16'h1A66, 0, "R7 shut down B with immediate copy");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule